// File: doc/BRIEF.md
# Float Compare and Select Unit

This unit executes the short-latency single-precision operations of a small programmable floating-point engine: magnitude (absolute value), greater-than and equality tests, raw copy, a select steered by a flag word, sign transfer from one operand to another, and an integer-arithmetic seed for the reciprocal square root. Every operation it accepts finishes in exactly two clock cycles. That fixed latency lets a sequencer plan when each result is written back without any handshake.

An issuing stage presents a 4-bit opcode, two 32-bit operands and a 32-bit flag word, together with a valid strobe. Two cycles later the unit raises its own valid strobe with the 32-bit result. Comparisons return their outcome as a single-precision number, 1.0 or 0.0, so it can feed later arithmetic directly. Opcodes the unit does not implement, and the no-operation code, are dropped at the input and never produce a result.

Top module: `fcs_unit`

## Requirements
- R1: An accepted operation presented with `in_valid` high in clock cycle n appears with `out_valid` high in cycle n+2. Successive cycles may each carry an operation, and results leave in issue order.
- R2: Opcode 0 (no-operation) and every opcode outside {4, 10, 11, 12, 13, 14, 15} produce no `out_valid` pulse. A cycle with `in_valid` low also produces none. While `out_valid` is low, `out_result` reads 0.
- R3: Opcode 4 (magnitude) returns operand a with bit 31 cleared and bits 30..0 unchanged.
- R4: Opcode 10 (greater-than) returns 0x3F800000 when a > b in single-precision order and 0x00000000 otherwise. Negative numbers rank below positive ones, and among negatives a larger magnitude ranks lower.
- R5: Opcode 11 (equality) returns 0x3F800000 when a equals b numerically and 0x00000000 otherwise. +0 (0x00000000) and -0 (0x80000000) count as equal.
- R6: If either operand of opcode 10 or 11 is a NaN (exponent bits 30..23 all ones, fraction bits 22..0 nonzero), the result is 0x00000000.
- R7: Opcode 12 (copy) returns the 32 bits of operand a unchanged.
- R8: Opcode 13 (select) returns operand a when the flag word is nonzero and operand b when the flag word is zero.
- R9: Opcode 14 (sign transfer) returns a with bit 31 inverted when b is strictly below zero, and a unchanged otherwise. A b of -0 or a NaN counts as not below zero.
- R10: Opcode 15 (root seed) returns 0x5F3759DF minus (a shifted right logically by one), computed in unsigned 32-bit arithmetic.
- R11: During synchronous active-low reset and in the cycle after it, `out_valid` is 0 and `out_result` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 4 | Opcode |
| in_a | input | 32 | Operand a |
| in_b | input | 32 | Operand b |
| in_flag | input | 32 | Flag word used by the select opcode |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 32 | Result word, zero when idle |

## Verification
A stage register that captured the wrong opcode or operand shows at the ports two cycles after issue: the result word is wrong, or a valid pulse is missing or spurious. Because the bench compares every cycle, a slip in the latency or in the order of results is reported in the first cycle it happens. The same holds for a stale result leaking out while idle. Comparison faults around signed zeros, NaNs and negative ordering, and a sign transfer that tests only bit 31, are each driven by specific operand pairs. These show as a one-word mismatch in that operation's result cycle.

// File: rtl/fcs_pkg.sv
// Shared definitions for the float compare and select unit.
// Assumes IEEE-754 single-precision layout: sign, 8-bit exponent, 23-bit fraction.
package fcs_pkg;

    localparam int EXP_W    = 8;
    localparam int MAN_W    = 23;
    localparam int WORD_W   = 1 + EXP_W + MAN_W;
    localparam int SIGN_POS = WORD_W - 1;
    localparam int OP_W     = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 4'd0,
        OP_ABS  = 4'd4,
        OP_GT   = 4'd10,
        OP_EQ   = 4'd11,
        OP_MOV  = 4'd12,
        OP_SEL  = 4'd13,
        OP_XSGN = 4'd14,
        OP_RSQ  = 4'd15
    } fcs_op_e;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [MAN_W-1:0] man;
    } fcs_float_t;

    // True for opcodes this unit executes.
    function automatic logic op_supported(logic [OP_W-1:0] op);
        case (op)
            4'd4, 4'd10, 4'd11, 4'd12, 4'd13, 4'd14, 4'd15: return 1'b1;
            default:                                        return 1'b0;
        endcase
    endfunction

    // True when the word encodes a NaN.
    function automatic logic is_nan(fcs_float_t f);
        return (&f.exp) && (|f.man);
    endfunction

    // True for +0 and -0.
    function automatic logic is_zero(fcs_float_t f);
        return (f.exp == '0) && (f.man == '0);
    endfunction

endpackage

// File: rtl/fcs_issue.sv
// Stage 1 of the unit: captures an operation and drops unsupported opcodes.
// Assumes in_op is meaningful only while in_valid is high; the flag word is
// reduced to one bit here since only its zero/nonzero state matters later.
module fcs_issue
    import fcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_op,
    input  logic [WORD_W-1:0] in_a,
    input  logic [WORD_W-1:0] in_b,
    input  logic [WORD_W-1:0] in_flag,
    output logic              s1_valid,
    output fcs_op_e           s1_op,
    output fcs_float_t        s1_a,
    output fcs_float_t        s1_b,
    output logic              s1_flag_set
);

    logic accept;

    // Decide whether this cycle carries an executable operation.
    always_comb begin
        accept = in_valid && op_supported(in_op);
    end

    // Valid bit of stage 1, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
        end else begin
            s1_valid <= accept;
        end
    end

    // Operand and opcode capture; held at zero when idle to keep the datapath quiet.
    always_ff @(posedge clk) begin
        if (!rst_n || !accept) begin
            s1_op       <= OP_NOP;
            s1_a        <= '0;
            s1_b        <= '0;
            s1_flag_set <= 1'b0;
        end else begin
            s1_op       <= fcs_op_e'(in_op);
            s1_a        <= in_a;
            s1_b        <= in_b;
            s1_flag_set <= |in_flag;
        end
    end

    // R1: a stage-1 operation came from a valid input one cycle earlier.
    assert_stage_from_input_R1: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> $past(in_valid));

    // R2: a no-operation code never occupies stage 1.
    assert_nop_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> ($past(in_op) != 4'd0));

endmodule

// File: rtl/fcs_cmp.sv
// Combinational single-precision comparator.
// Produces greater-than and equality with signed-zero equivalence; any NaN
// operand forces both outcomes false.
module fcs_cmp
    import fcs_pkg::*;
(
    input  fcs_float_t a,
    input  fcs_float_t b,
    output logic       gt,
    output logic       eq,
    output logic       any_nan
);

    logic                    both_zero;
    logic                    mag_gt;
    logic                    mag_lt;
    logic [EXP_W+MAN_W-1:0]  mag_a;
    logic [EXP_W+MAN_W-1:0]  mag_b;

    // Magnitude fields and special-value classification.
    always_comb begin
        mag_a     = {a.exp, a.man};
        mag_b     = {b.exp, b.man};
        mag_gt    = mag_a > mag_b;
        mag_lt    = mag_a < mag_b;
        both_zero = is_zero(a) && is_zero(b);
        any_nan   = is_nan(a) || is_nan(b);
    end

    // Ordering by sign first, then by magnitude in the direction the sign sets.
    always_comb begin
        gt = 1'b0;
        eq = 1'b0;
        if (!any_nan) begin
            if (both_zero) begin
                eq = 1'b1;
            end else if (a.sign != b.sign) begin
                gt = !a.sign;
            end else begin
                eq = (mag_a == mag_b);
                gt = a.sign ? mag_lt : mag_gt;
            end
        end
    end

    // R4: greater-than and equality are never both true.
    always_comb begin
        assert_cmp_exclusive_R4: assert (!(gt && eq));
    end

    // R6: a NaN operand yields neither outcome.
    always_comb begin
        assert_nan_unordered_R6: assert (!(any_nan && (gt || eq)));
    end

endmodule

// File: rtl/fcs_sign.sv
// Combinational sign handling: magnitude, sign transfer and flag select.
// Negation flips the sign bit only; -0 and NaN in b are not treated as negative.
module fcs_sign
    import fcs_pkg::*;
(
    input  fcs_float_t a,
    input  fcs_float_t b,
    input  logic       flag_set,
    output fcs_float_t abs_res,
    output fcs_float_t xsgn_res,
    output fcs_float_t sel_res
);

    logic b_below_zero;

    // Detect a strictly negative b.
    always_comb begin
        b_below_zero = b.sign && !is_zero(b) && !is_nan(b);
    end

    // Build the three sign-related results.
    always_comb begin
        abs_res       = a;
        abs_res.sign  = 1'b0;
        xsgn_res      = a;
        xsgn_res.sign = a.sign ^ b_below_zero;
        sel_res       = flag_set ? a : b;
    end

    // R9: sign transfer never alters the exponent or fraction.
    always_comb begin
        assert_xsgn_body_R9: assert ({xsgn_res.exp, xsgn_res.man} == {a.exp, a.man});
    end

endmodule

// File: rtl/fcs_unit.sv
// Top of the float compare and select unit: two-stage pipeline.
// Stage 1 (fcs_issue) captures the operation; stage 2 evaluates and registers
// the result. Results read zero whenever out_valid is low.
module fcs_unit
    import fcs_pkg::*;
#(
    parameter logic [31:0] ONE_ENC    = 32'h3F80_0000,
    parameter logic [31:0] SEED_MAGIC = 32'h5F37_59DF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [3:0]  in_op,
    input  logic [31:0] in_a,
    input  logic [31:0] in_b,
    input  logic [31:0] in_flag,
    output logic        out_valid,
    output logic [31:0] out_result
);

    localparam logic [WORD_W-1:0] ZERO_ENC = '0;

    logic        s1_valid;
    fcs_op_e     s1_op;
    fcs_float_t  s1_a;
    fcs_float_t  s1_b;
    logic        s1_flag_set;

    logic        cmp_gt;
    logic        cmp_eq;
    logic        cmp_nan;
    fcs_float_t  abs_res;
    fcs_float_t  xsgn_res;
    fcs_float_t  sel_res;
    logic [WORD_W-1:0] s2_next;

    fcs_issue u_issue (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_op       (in_op),
        .in_a        (in_a),
        .in_b        (in_b),
        .in_flag     (in_flag),
        .s1_valid    (s1_valid),
        .s1_op       (s1_op),
        .s1_a        (s1_a),
        .s1_b        (s1_b),
        .s1_flag_set (s1_flag_set)
    );

    fcs_cmp u_cmp (
        .a       (s1_a),
        .b       (s1_b),
        .gt      (cmp_gt),
        .eq      (cmp_eq),
        .any_nan (cmp_nan)
    );

    fcs_sign u_sign (
        .a        (s1_a),
        .b        (s1_b),
        .flag_set (s1_flag_set),
        .abs_res  (abs_res),
        .xsgn_res (xsgn_res),
        .sel_res  (sel_res)
    );

    // Select the stage-2 result for the opcode held in stage 1.
    always_comb begin
        case (s1_op)
            OP_ABS:  s2_next = abs_res;
            OP_GT:   s2_next = cmp_gt ? ONE_ENC : ZERO_ENC;
            OP_EQ:   s2_next = cmp_eq ? ONE_ENC : ZERO_ENC;
            OP_MOV:  s2_next = s1_a;
            OP_SEL:  s2_next = sel_res;
            OP_XSGN: s2_next = xsgn_res;
            OP_RSQ:  s2_next = SEED_MAGIC - (s1_a >> 1);
            default: s2_next = ZERO_ENC;
        endcase
    end

    // Output register; the result is forced to zero when no operation completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid  <= s1_valid;
            out_result <= s1_valid ? s2_next : ZERO_ENC;
        end
    end

    // R1: an output pulse is backed by a stage-1 operation one cycle earlier.
    assert_out_from_stage_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(s1_valid));

    // R2: the result port is zero while idle.
    assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_result == 32'h0));

    // R3: magnitude results have a clear sign bit.
    assert_abs_sign_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(s1_op == OP_ABS)) |-> !out_result[31]);

    // R4: greater-than results are either 1.0 or 0.0.
    assert_gt_encoding_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(s1_op == OP_GT)) |-> (out_result == ONE_ENC || out_result == 32'h0));

    // R5: equality results are either 1.0 or 0.0.
    assert_eq_encoding_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(s1_op == OP_EQ)) |-> (out_result == ONE_ENC || out_result == 32'h0));

    // R11: the cycle after reset shows no output.
    assert_reset_quiet_R11: assert property (@(posedge clk)
        $past(!rst_n) |-> (!out_valid && out_result == 32'h0));

endmodule

// File: tb/fcs_unit_test.sv
// Self-checking bench: a behavioural two-deep model compared on every cycle.
module fcs_unit_test;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_op = 4'd0;
    logic [31:0] in_a = 32'h0;
    logic [31:0] in_b = 32'h0;
    logic [31:0] in_flag = 32'h0;
    logic        out_valid;
    logic [31:0] out_result;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // model stages: index 1 = after one edge, 2 = at the output
    bit          m_v1 = 0, m_v2 = 0;
    logic [31:0] m_r1 = 0, m_r2 = 0;
    string       m_t1 = "R11", m_t2 = "R11";
    bit          m_rst2 = 1, m_rst1 = 1;

    fcs_unit uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_op      (in_op),
        .in_a       (in_a),
        .in_b       (in_b),
        .in_flag    (in_flag),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit nan_of(logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction

    function automatic real val_of(logic [31:0] x);
        int  e = int'(x[30:23]);
        real m;
        if (e == 0) m = real'(x[22:0]) * (2.0 ** (-149));
        else        m = (8388608.0 + real'(x[22:0])) * (2.0 ** (e - 150));
        return x[31] ? -m : m;
    endfunction

    function automatic bit known_op(logic [3:0] op);
        return op == 4 || (op >= 10);
    endfunction

    function automatic logic [31:0] ref_result(logic [3:0] op, logic [31:0] a,
                                               logic [31:0] b, logic [31:0] f);
        bit un = nan_of(a) || nan_of(b);
        case (op)
            4'd4:  return {1'b0, a[30:0]};
            4'd10: return (!un && val_of(a) > val_of(b)) ? 32'h3F800000 : 32'h0;
            4'd11: return (!un && val_of(a) == val_of(b)) ? 32'h3F800000 : 32'h0;
            4'd12: return a;
            4'd13: return (f != 0) ? a : b;
            4'd14: return (!nan_of(b) && val_of(b) < 0.0) ? (a ^ 32'h80000000) : a;
            4'd15: return 32'h5F3759DF - (a >> 1);
            default: return 32'h0;
        endcase
    endfunction

    function automatic string ref_tag(logic [3:0] op, logic [31:0] a, logic [31:0] b);
        case (op)
            4'd4:  return "R3";
            4'd10: return (nan_of(a) || nan_of(b)) ? "R6" : "R4";
            4'd11: return (nan_of(a) || nan_of(b)) ? "R6" : "R5";
            4'd12: return "R7";
            4'd13: return "R8";
            4'd14: return "R9";
            4'd15: return "R10";
            default: return "R2";
        endcase
    endfunction

    // Advance the model by the edge just passed, then compare the outputs.
    task automatic advance_and_check();
        string vt;
        m_v2 = m_v1; m_r2 = m_r1; m_t2 = m_t1; m_rst2 = m_rst1;
        if (!rst_n) begin
            m_v1 = 0; m_r1 = 0; m_t1 = "R11"; m_rst1 = 1;
            m_v2 = 0; m_r2 = 0; m_t2 = "R11"; m_rst2 = 1;
        end else begin
            m_rst1 = 0;
            m_v1 = in_valid && known_op(in_op);
            m_r1 = m_v1 ? ref_result(in_op, in_a, in_b, in_flag) : 32'h0;
            m_t1 = m_v1 ? ref_tag(in_op, in_a, in_b) : "R2";
        end
        vt = m_rst2 ? "R11" : (m_v2 ? "R1" : "R2");
        checks++;
        if (out_valid !== m_v2) begin
            errors++;
            $display("FAIL %s out_valid actual=%0b expected=%0b", vt, out_valid, m_v2);
        end
        checks++;
        if (out_result !== m_r2) begin
            errors++;
            $display("FAIL %s out_result actual=%08h expected=%08h", m_t2, out_result, m_r2);
        end
    endtask

    task automatic step(input bit v, input logic [3:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] f);
        @(negedge clk);
        advance_and_check();
        in_valid = v; in_op = op; in_a = a; in_b = b; in_flag = f;
    endtask

    initial begin
        // R11: reset state
        repeat (3) step(0, 4'd10, 32'h3F800000, 32'h0, 32'h0);
        @(negedge clk);
        advance_and_check();
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        // R3 magnitude
        step(1, 4'd4,  32'hC0490FDB, 32'h0, 32'h0);
        step(1, 4'd4,  32'h80000000, 32'h0, 32'h0);
        // R4 ordering, back to back (R1)
        step(1, 4'd10, 32'h40000000, 32'h3F800000, 0);
        step(1, 4'd10, 32'hC0000000, 32'hBF800000, 0);
        step(1, 4'd10, 32'hBF800000, 32'hC0000000, 0);
        step(1, 4'd10, 32'h3F800000, 32'hC0000000, 0);
        step(1, 4'd10, 32'h00000000, 32'h80000000, 0);
        step(1, 4'd10, 32'h3F800000, 32'h3F800000, 0);
        // R5 equality including signed zeros
        step(1, 4'd11, 32'h80000000, 32'h00000000, 0);
        step(1, 4'd11, 32'h3F800000, 32'h3F800000, 0);
        step(1, 4'd11, 32'h3F800000, 32'hBF800000, 0);
        // R6 NaN
        step(1, 4'd11, 32'h7FC00000, 32'h7FC00000, 0);
        step(1, 4'd10, 32'h7F800001, 32'h00000000, 0);
        step(1, 4'd10, 32'h3F800000, 32'hFFC00000, 0);
        // R7 copy
        step(1, 4'd12, 32'hDEADBEEF, 32'h12345678, 0);
        // R8 select
        step(1, 4'd13, 32'h11111111, 32'h22222222, 32'h00000000);
        step(1, 4'd13, 32'h11111111, 32'h22222222, 32'h80000000);
        // R9 sign transfer
        step(1, 4'd14, 32'h40400000, 32'hBF800000, 0);
        step(1, 4'd14, 32'hC0400000, 32'hBF800000, 0);
        step(1, 4'd14, 32'h40400000, 32'h80000000, 0);
        step(1, 4'd14, 32'h40400000, 32'hFFC00000, 0);
        step(1, 4'd14, 32'h40400000, 32'h3F800000, 0);
        // R10 seed
        step(1, 4'd15, 32'h40800000, 0, 0);
        step(1, 4'd15, 32'hFFFFFFFF, 0, 0);
        // R2 dropped opcodes and idle with opcode present
        step(1, 4'd0,  32'h3F800000, 32'h3F800000, 0);
        step(1, 4'd5,  32'h3F800000, 32'h3F800000, 0);
        step(1, 4'd1,  32'h3F800000, 32'h3F800000, 0);
        step(0, 4'd12, 32'hCAFEF00D, 32'h0, 0);
        step(1, 4'd12, 32'h0BADC0DE, 32'h0, 0);
        // mixed stream over all opcodes
        for (int i = 0; i < 80; i++) begin
            logic [31:0] ra = $urandom;
            logic [31:0] rb = (i % 4 == 0) ? ra : $urandom;
            logic [31:0] rf = (i % 3 == 0) ? 32'h0 : $urandom;
            step((i % 7) != 0, 4'($urandom % 16), ra, rb, rf);
        end
        repeat (3) step(0, 0, 0, 0, 0);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule